// File: doc/BRIEF.md
# Relative Branch and Loop Resolver

This unit settles the control-flow outcome of one relative transfer instruction per clock. It takes the instruction kind, a 4-bit condition code, the five arithmetic flags, the instruction's own address and length, a displacement and the count register. It returns the address of the next instruction to run, the new count value and, for the conditional-set operation, the byte to store. Every kind that redirects flow measures its displacement from the end of the instruction, which is `ip_i + len_i`, and never from its start.

The unit covers three groups of instructions. The first group is the unconditional jumps: the short form with an 8-bit displacement and the near form with a 16-bit displacement. The second group is the flag-tested branches and the counted-loop variants, which decrement the count before they test it. The third group is the conditional-set operation, which never redirects flow. Far targets, indirect targets, memory operands and fetch are handled elsewhere in the pipeline. Results are registered and appear one clock after the request.

Top module: `brc_unit`

## Requirements
- R1: The outputs `valid_o`, `taken_o`, `next_ip_o`, `cx_o` and `set_byte_o` update on the rising clock edge that samples `valid_i` high. They then hold their value until the next accepted request. `valid_o` equals `valid_i` delayed by one clock. While `rst_ni` is low, every output is 0.
- R2: Kind encoding on `kind_i` is as follows. 0 is the short jump, 1 is the near jump, 2 is the conditional branch, 3 is the plain loop, 4 is the loop-while-zero, 5 is the loop-while-not-zero, 6 is the conditional set and 7 is reserved. A short jump is always taken. Its target is `ip_i + len_i + sign_extend(disp_i[7:0])`, so it reaches from -128 to +127 bytes.
- R3: A near jump is always taken. Its target is `ip_i + len_i + disp_i`, with the full 16-bit signed displacement.
- R4: All next-address sums wrap modulo 2^16.
- R5: A conditional branch uses the 8-bit sign-extended displacement. If the condition is true, `taken_o` is 1 and `next_ip_o` is the target. If the condition is false, `taken_o` is 0 and `next_ip_o` is `ip_i + len_i`.
- R6: The flag bit positions in `flags_i` are: bit 0 is carry C, bit 1 is parity P, bit 2 is zero Z, bit 3 is sign S and bit 4 is overflow O. The base tests, indexed by `cc_i[3:1]`, are: 0 is O, 1 is C, 2 is Z, 3 is C|Z, 4 is S, 5 is P, 6 is S^O and 7 is Z|(S^O). When `cc_i[0]` is 1, the base test is inverted.
- R7: The plain loop sets `cx_o = cx_i - 1`, with modulo 2^16 wrap. It is taken, using the 8-bit displacement, exactly when that decremented value is non-zero.
- R8: The loop-while-zero kind is taken only when the decremented count is non-zero and Z is 1. The loop-while-not-zero kind is taken only when the decremented count is non-zero and Z is 0.
- R9: All three loop kinds output the decremented count even when they are not taken.
- R10: The conditional set puts 8'h01 on `set_byte_o` when the R6 condition is true and 8'h00 when it is false. For this kind, `taken_o` is 0 and `next_ip_o` is `ip_i + len_i`.
- R11: Every kind other than the three loop kinds passes `cx_i` through unchanged to `cx_o`. Every kind other than the conditional set gives `set_byte_o = 8'h00`.
- R12: The reserved kind 7 is never taken. It gives `next_ip_o = ip_i + len_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| kind_i | input | 3 | Instruction kind (R2 encoding) |
| cc_i | input | 4 | Condition code (R6 encoding) |
| flags_i | input | 5 | Flags {O,S,Z,P,C} |
| ip_i | input | 16 | Address of the instruction |
| len_i | input | 4 | Instruction length in bytes |
| disp_i | input | 16 | Signed displacement; low byte only for short forms |
| cx_i | input | 16 | Count register value |
| valid_o | output | 1 | Result present |
| taken_o | output | 1 | Control transfer taken |
| next_ip_o | output | 16 | Address of the next instruction |
| cx_o | output | 16 | Updated count register |
| set_byte_o | output | 8 | Conditional-set result byte |

## Verification
Every result passes through exactly one register, so a request applied on a falling edge is captured on the next rising edge. The bench therefore changes inputs on falling edges and reads all five outputs on the falling edge that follows, one full period later, when they have been stable for half a cycle. The bench sweeps every combination of condition code and flag pattern for both the conditional branch and the conditional set. Directed cases cover the displacement extremes, the wrap of the address sum and the count values 0, 1, 2 and FFFFh.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    K_SHORT  = 3'd0,
    K_NEAR   = 3'd1,
    K_JCC    = 3'd2,
    K_LOOP   = 3'd3,
    K_LOOPZ  = 3'd4,
    K_LOOPNZ = 3'd5,
    K_SETCC  = 3'd6,
    K_RSVD   = 3'd7
  } kind_e;

  typedef struct packed {
    logic o;
    logic s;
    logic z;
    logic p;
    logic c;
  } flags_t;
endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  logic [3:0] cc_i,
  input  flags_t     flags_i,
  output logic       cond_o
);
  logic base;
  logic lt;

  assign lt = flags_i.s ^ flags_i.o;

  always_comb begin
    unique case (cc_i[3:1])
      3'd0: base = flags_i.o;
      3'd1: base = flags_i.c;
      3'd2: base = flags_i.z;
      3'd3: base = flags_i.c | flags_i.z;
      3'd4: base = flags_i.s;
      3'd5: base = flags_i.p;
      3'd6: base = lt;
      default: base = flags_i.z | lt;
    endcase
  end

  // odd codes select the inverted sense
  assign cond_o = base ^ cc_i[0];
endmodule

// File: rtl/brc_target_gen.sv
module brc_target_gen #(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 4,
  parameter int SHORT_W = 8
) (
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic              use_short_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] tgt_o
);
  localparam int EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] disp_short;
  logic [ADDR_W-1:0] disp_sel;

  generate
    if (EXT_W > 0) begin : g_ext
      assign disp_short = {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
    end else begin : g_pass
      assign disp_short = disp_i;
    end
  endgenerate

  assign disp_sel = use_short_i ? disp_short : disp_i;
  // displacement is relative to the end of the instruction
  assign seq_o    = ip_i + {{(ADDR_W-LEN_W){1'b0}}, len_i};
  assign tgt_o    = seq_o + disp_sel;
endmodule

// File: rtl/brc_loop_ctl.sv
module brc_loop_ctl
  import brc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  kind_e             kind_i,
  input  logic              z_i,
  input  logic [CNT_W-1:0]  cx_i,
  output logic              is_loop_o,
  output logic              loop_go_o,
  output logic [CNT_W-1:0]  cx_o
);
  logic [CNT_W-1:0] cx_dec;
  logic             live;

  assign cx_dec = cx_i - CNT_W'(1);
  assign live   = |cx_dec;

  always_comb begin
    is_loop_o = 1'b1;
    loop_go_o = 1'b0;
    unique case (kind_i)
      K_LOOP:   loop_go_o = live;
      K_LOOPZ:  loop_go_o = live & z_i;
      K_LOOPNZ: loop_go_o = live & ~z_i;
      default:  is_loop_o = 1'b0;
    endcase
  end

  // decrement applies whether or not the loop is taken
  assign cx_o = is_loop_o ? cx_dec : cx_i;
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  parameter int LEN_W   = 4,
  parameter int SHORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        kind_i,
  input  logic [3:0]        cc_i,
  input  logic [4:0]        flags_i,
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [CNT_W-1:0]  cx_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_ip_o,
  output logic [CNT_W-1:0]  cx_o,
  output logic [7:0]        set_byte_o
);
  kind_e             kind;
  flags_t            flags;
  logic              cond;
  logic              use_short;
  logic [ADDR_W-1:0] seq_ip, tgt_ip;
  logic              is_loop, loop_go;
  logic [CNT_W-1:0]  cx_nxt;
  logic              take_nxt;
  logic [7:0]        byte_nxt;

  assign kind      = kind_e'(kind_i);
  assign flags     = flags_t'(flags_i);
  assign use_short = (kind != K_NEAR);

  brc_cond_eval u_cond (
    .cc_i   (cc_i),
    .flags_i(flags),
    .cond_o (cond)
  );

  brc_target_gen #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .SHORT_W(SHORT_W)
  ) u_tgt (
    .ip_i       (ip_i),
    .len_i      (len_i),
    .disp_i     (disp_i),
    .use_short_i(use_short),
    .seq_o      (seq_ip),
    .tgt_o      (tgt_ip)
  );

  brc_loop_ctl #(
    .CNT_W(CNT_W)
  ) u_loop (
    .kind_i   (kind),
    .z_i      (flags.z),
    .cx_i     (cx_i),
    .is_loop_o(is_loop),
    .loop_go_o(loop_go),
    .cx_o     (cx_nxt)
  );

  always_comb begin
    take_nxt = 1'b0;
    byte_nxt = 8'h00;
    unique case (kind)
      K_SHORT, K_NEAR: take_nxt = 1'b1;
      K_JCC:           take_nxt = cond;
      K_SETCC:         byte_nxt = {7'd0, cond};
      default:         take_nxt = is_loop & loop_go;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      taken_o    <= 1'b0;
      next_ip_o  <= '0;
      cx_o       <= '0;
      set_byte_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        taken_o    <= take_nxt;
        next_ip_o  <= take_nxt ? tgt_ip : seq_ip;
        cx_o       <= cx_nxt;
        set_byte_o <= byte_nxt;
      end
    end
  end
endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        kind_i,
  input logic [ADDR_W-1:0] ip_i,
  input logic [LEN_W-1:0]  len_i,
  input logic [CNT_W-1:0]  cx_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] next_ip_o,
  input logic [CNT_W-1:0]  cx_o,
  input logic [7:0]        set_byte_o
);
  p_valid_follows_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_uncond_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i <= 3'd1) |=> taken_o);

  p_seq_when_not_taken_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (taken_o || next_ip_o == $past(ip_i) + ADDR_W'($past(len_i))));

  p_loop_dec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i >= 3'd3 && kind_i <= 3'd5) |=> cx_o == $past(cx_i) - CNT_W'(1));

  p_loop_zero_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i >= 3'd3 && kind_i <= 3'd5 && cx_i == CNT_W'(1)) |=> !taken_o);

  p_setcc_seq_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 3'd6) |=> (!taken_o && set_byte_o[7:1] == 7'd0));

  p_cx_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (kind_i <= 3'd2 || kind_i >= 3'd6)) |=> cx_o == $past(cx_i));

  p_rsvd_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && kind_i == 3'd7) |=> (!taken_o && set_byte_o == 8'h00));
endmodule

bind brc_unit brc_unit_chk #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W),
  .LEN_W (LEN_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .kind_i    (kind_i),
  .ip_i      (ip_i),
  .len_i     (len_i),
  .cx_i      (cx_i),
  .valid_o   (valid_o),
  .taken_o   (taken_o),
  .next_ip_o (next_ip_o),
  .cx_o      (cx_o),
  .set_byte_o(set_byte_o)
);

// File: tb/tb_brc_unit.sv
`timescale 1ns/1ps
module tb_brc_unit;
  localparam logic [2:0] KS = 3'd0, KN = 3'd1, KJ = 3'd2, KL = 3'd3,
                         KLZ = 3'd4, KLNZ = 3'd5, KSET = 3'd6, KR = 3'd7;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  kind_i = '0;
  logic [3:0]  cc_i = '0;
  logic [4:0]  flags_i = '0;
  logic [15:0] ip_i = '0;
  logic [3:0]  len_i = '0;
  logic [15:0] disp_i = '0;
  logic [15:0] cx_i = '0;
  logic        valid_o, taken_o;
  logic [15:0] next_ip_o, cx_o;
  logic [7:0]  set_byte_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  brc_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .kind_i(kind_i),
    .cc_i(cc_i), .flags_i(flags_i), .ip_i(ip_i), .len_i(len_i),
    .disp_i(disp_i), .cx_i(cx_i), .valid_o(valid_o), .taken_o(taken_o),
    .next_ip_o(next_ip_o), .cx_o(cx_o), .set_byte_o(set_byte_o)
  );

  function automatic bit ref_cond(input logic [3:0] cc, input logic [4:0] f);
    bit c = f[0], p = f[1], z = f[2], s = f[3], o = f[4];
    bit b;
    case (cc[3:1])
      3'd0: b = o;
      3'd1: b = c;
      3'd2: b = z;
      3'd3: b = c | z;
      3'd4: b = s;
      3'd5: b = p;
      3'd6: b = s ^ o;
      default: b = z | (s ^ o);
    endcase
    return b ^ cc[0];
  endfunction

  task automatic check(input string tag, input bit et, input logic [15:0] eip,
                       input logic [15:0] ecx, input logic [7:0] eb);
    checks++;
    if (valid_o !== 1'b1 || taken_o !== et || next_ip_o !== eip ||
        cx_o !== ecx || set_byte_o !== eb) begin
      errors++;
      $display("FAIL %s: got v=%b t=%b ip=%h cx=%h b=%h exp v=1 t=%b ip=%h cx=%h b=%h",
               tag, valid_o, taken_o, next_ip_o, cx_o, set_byte_o, et, eip, ecx, eb);
    end
  endtask

  // apply on a falling edge, capture on the rising edge, read one period later
  task automatic run(input string tag, input logic [2:0] k, input logic [3:0] cc,
                     input logic [4:0] f, input logic [15:0] ip, input logic [3:0] ln,
                     input logic [15:0] d, input logic [15:0] cx);
    logic [15:0] seq, tgt, dsel, ecx;
    bit et;
    logic [7:0] eb;
    bit cnd;
    valid_i = 1'b1; kind_i = k; cc_i = cc; flags_i = f;
    ip_i = ip; len_i = ln; disp_i = d; cx_i = cx;
    @(negedge clk);
    seq  = 16'(ip + {12'd0, ln});
    dsel = (k == KN) ? d : {{8{d[7]}}, d[7:0]};
    tgt  = 16'(seq + dsel);
    cnd  = ref_cond(cc, f);
    ecx  = cx; et = 1'b0; eb = 8'h00;
    case (k)
      KS, KN: et = 1'b1;
      KJ:     et = cnd;
      KL:     begin ecx = 16'(cx - 16'd1); et = (ecx != 0); end
      KLZ:    begin ecx = 16'(cx - 16'd1); et = (ecx != 0) && f[2]; end
      KLNZ:   begin ecx = 16'(cx - 16'd1); et = (ecx != 0) && !f[2]; end
      KSET:   eb = cnd ? 8'h01 : 8'h00;
      default: ;
    endcase
    check(tag, et, et ? tgt : seq, ecx, eb);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13-style reset state, stated under R1
    checks++;
    if (valid_o !== 0 || taken_o !== 0 || next_ip_o !== 0 || cx_o !== 0 || set_byte_o !== 0) begin
      errors++;
      $display("FAIL R1 reset: got %b %b %h %h %h exp all zero",
               valid_o, taken_o, next_ip_o, cx_o, set_byte_o);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 short jump extremes
    run("R2 short +127", KS, 4'd0, 5'd0, 16'h1000, 4'd2, 16'h007F, 16'h0033);
    run("R2 short -128", KS, 4'd0, 5'd0, 16'h1000, 4'd2, 16'hAA80, 16'h0033);
    // R3 near jump
    run("R3 near fwd", KN, 4'd0, 5'd0, 16'h2000, 4'd3, 16'h1234, 16'h0001);
    run("R3 near back", KN, 4'd0, 5'd0, 16'h2000, 4'd3, 16'h8000, 16'h0001);
    // R4 wrap
    run("R4 wrap near", KN, 4'd0, 5'd0, 16'hFFF0, 4'd5, 16'h0020, 16'h0000);
    run("R4 wrap short", KS, 4'd0, 5'd0, 16'h0004, 4'd2, 16'h00F0, 16'h0000);
    run("R4 wrap seq", KR, 4'd0, 5'd0, 16'hFFFE, 4'd4, 16'h0000, 16'h0007);

    // R5 R6 full sweep of conditional branch; R10 R11 sweep of set
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 32; f++)
        run("R5 R6 jcc sweep", KJ, 4'(cc), 5'(f), 16'(16'h4000 + cc * 64 + f),
            4'(2 + (f % 3)), 16'(16'hFF00 + f * 7), 16'(16'h0100 + f));
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 32; f++)
        run("R10 R11 setcc sweep", KSET, 4'(cc), 5'(f), 16'(16'h6000 + f),
            4'd3, 16'h0010, 16'(16'h0500 + cc));

    // R7 R8 R9 loop family across counts and Z
    for (int k = 3; k <= 5; k++)
      for (int z = 0; z < 2; z++) begin
        run("R7 R8 R9 cx=0", 3'(k), 4'd0, 5'(z << 2), 16'h3000, 4'd2, 16'h00FA, 16'h0000);
        run("R7 R8 R9 cx=1", 3'(k), 4'd0, 5'(z << 2), 16'h3000, 4'd2, 16'h00FA, 16'h0001);
        run("R7 R8 R9 cx=2", 3'(k), 4'd0, 5'(z << 2), 16'h3000, 4'd2, 16'h00FA, 16'h0002);
        run("R7 R8 R9 cx=ffff", 3'(k), 4'd0, 5'(z << 2), 16'h3000, 4'd2, 16'h0010, 16'hFFFF);
      end

    // R12 reserved kind, several flag patterns
    run("R12 rsvd a", KR, 4'd4, 5'h1F, 16'h7000, 4'd1, 16'h0040, 16'h0009);
    run("R12 rsvd b", KR, 4'd5, 5'h00, 16'h7100, 4'd6, 16'h8000, 16'h0000);

    // R1 outputs hold while valid_i is low
    valid_i = 1'b0; kind_i = KN; disp_i = 16'h0100; ip_i = 16'h0000; cx_i = 16'hBEEF;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || next_ip_o !== 16'h7106 || cx_o !== 16'h0000) begin
      errors++;
      $display("FAIL R1 hold: got v=%b ip=%h cx=%h exp v=0 ip=7106 cx=0000",
               valid_o, next_ip_o, cx_o);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule